// File: doc/BRIEF.md
# Event-Measuring Reload/Capture Down Counter

This block is a 16-bit down counter with a programmable prescaler, a reload register and a capture register. It times intervals between external events. Two asynchronous event inputs are synchronised and edge-detected, and each input has its own selectable active polarity. Events count only while the software run control is high. Raising the run control also starts the prescaler and the counter.

With reloading disabled, the counter runs freely. It wraps from 0000h to FFFFh, and events on input 2 only sample it. With reloading enabled, a two-bit source select picks the restart trigger:
- value 01 makes every active edge on input 1 reload the counter and restart the countdown;
- value 00 reloads once, on the rising edge of the run control.

An active edge on input 2 captures the live count. Each input owns an event flag and an overrun error flag. Software clears the flags through a write-one-to-clear port.

Top module: `evt_reload_timer`

## Requirements
- R1: After synchronous reset, `count_o`, `capture_o` and `flags_o` are all zero. The flag bits are: bit 0 = event flag 1, bit 1 = error flag 1, bit 2 = event flag 2, bit 3 = error flag 2.
- R2: While `run_i` is high, the counter decreases by one once every `div_i`+1 clocks and wraps from 0000h to FFFFh. With `div_i` = 3 and a fresh start, the first step lands on the 4th clock edge after `run_i` rises. While `run_i` is low the count holds and the prescaler restarts.
- R3: While `run_i` is low, edges on both event inputs are ignored: no reload, no capture, no flag change.
- R4: When `reload_en_i` is low, or `src_sel_i` is 10 or 11, the counter is never reloaded. Input 1 has no effect on the counter or the flags, and input 2 still captures.
- R5: With `reload_en_i` high and `src_sel_i` = 01, an active edge on input 1 loads `count_o` from the reload register and sets event flag 1. The action appears on the third rising clock edge after the pin changes.
- R6: If event flag 1 is already set when an input-1 reload happens, error flag 1 is set in the same cycle as that reload.
- R7: An active edge on input 2 while running copies the current count into `capture_o` and sets event flag 2.
- R8: An input-2 edge while event flag 2 is set sets error flag 2 and leaves `capture_o` unchanged. No capture happens while either event flag 2 or error flag 2 is set.
- R9: When a capture and an input-1 reload fall in the same cycle, `capture_o` receives the count from before the reload, and the counter takes the reload value.
- R10: Polarity control `polN_i` = 0 makes the rising edge of input N active. A value of 1 makes the falling edge active. The other edge is ignored.
- R11: With `reload_en_i` high and `src_sel_i` = 00, the rising edge of `run_i` reloads the counter one clock later and sets event flag 1. Input-1 edges do not reload in this mode.
- R12: Writing `clr_we_i` with a 1 in a `clr_mask_i` bit clears that flag. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Software run control |
| reload_en_i | input | 1 | Enables restart-by-reload modes |
| src_sel_i | input | 2 | Restart source: 00 run edge, 01 input 1 |
| pol1_i | input | 1 | Input 1 active edge (0 rising, 1 falling) |
| pol2_i | input | 1 | Input 2 active edge (0 rising, 1 falling) |
| div_i | input | 16 | Prescaler divide value minus one |
| ev1_i | input | 1 | Asynchronous event input 1 |
| ev2_i | input | 1 | Asynchronous event input 2 |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 16 | Reload register write data |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 4 | Write-one-to-clear mask for the flags |
| count_o | output | 16 | Live counter value |
| capture_o | output | 16 | Capture register |
| flags_o | output | 4 | Event and error flags |

## Verification
The bench aims at the capture lockout:
- It clears only event flag 2 while error flag 2 stays set. A design that unlocked on event flag 2 alone would overwrite `capture_o`.
- It fires both inputs in the same cycle. A reload-first design would capture the reload value instead of the old count.

It also checks the prescaler step at the wrap through 0000h, where a design with an off-by-one divider steps on the wrong edge. Other targets:
- a flag clear that lands on the same edge as a reload, where clear-wins logic would lose event flag 1;
- an input-1 edge in the software-restart mode and while stopped, which must not reload.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    SRC_RUN_EDGE = 2'b00,
    SRC_INPUT1   = 2'b01,
    SRC_RSVD2    = 2'b10,
    SRC_RSVD3    = 2'b11
  } restart_src_e;

  localparam int FLAG_EV1 = 0;
  localparam int FLAG_ER1 = 1;
  localparam int FLAG_EV2 = 2;
  localparam int FLAG_ER2 = 3;
  localparam int NFLAGS   = 4;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = fall_i ? (prev_q & ~sync_q[STAGES-1])
                         : (~prev_q & sync_q[STAGES-1]);
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_flag_pair.sv
module evt_flag_pair #(
  parameter bit LOCK_ON_ERR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic clr_ev_i,
  input  logic clr_er_i,
  output logic accept_o,
  output logic ev_o,
  output logic er_o
);
  logic overrun;
  logic blocked;

  assign overrun  = hit_i && ev_o;
  assign blocked  = LOCK_ON_ERR ? (ev_o || er_o) : 1'b0;
  assign accept_o = hit_i && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_o <= 1'b0;
      er_o <= 1'b0;
    end else begin
      if (accept_o)      ev_o <= 1'b1;
      else if (clr_ev_i) ev_o <= 1'b0;
      if (overrun)       er_o <= 1'b1;
      else if (clr_er_i) er_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_reload_timer.sv
module evt_reload_timer
  import evt_timer_pkg::*;
#(
  parameter int W      = 16,
  parameter int PW     = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              reload_en_i,
  input  logic [1:0]        src_sel_i,
  input  logic              pol1_i,
  input  logic              pol2_i,
  input  logic [PW-1:0]     div_i,
  input  logic              ev1_i,
  input  logic              ev2_i,
  input  logic              reload_we_i,
  input  logic [W-1:0]      reload_wdata_i,
  input  logic              clr_we_i,
  input  logic [NFLAGS-1:0] clr_mask_i,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      capture_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam int NIN = 2;

  logic [NIN-1:0] pins, pols, edges;
  logic [W-1:0]   reload_q;
  logic           run_q, run_rise, tick;
  logic           mode_in1, mode_run;
  logic           reload_hit, cap_hit, cap_accept, unused_accept;
  logic           ev1_f, er1_f, ev2_f, er2_f;
  logic [NFLAGS-1:0] clr;
  restart_src_e   src;

  assign pins = {ev2_i, ev1_i};
  assign pols = {pol2_i, pol1_i};
  assign src  = restart_src_e'(src_sel_i);

  for (genvar i = 0; i < NIN; i++) begin : g_in
    evt_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_i(pins[i]), .fall_i(pols[i]), .edge_o(edges[i])
    );
  end

  evt_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst(rst), .run_i(run_i), .div_i(div_i), .tick_o(tick)
  );

  assign run_rise   = run_i && !run_q;
  assign mode_in1   = reload_en_i && (src == SRC_INPUT1);
  assign mode_run   = reload_en_i && (src == SRC_RUN_EDGE);
  assign reload_hit = run_i && ((mode_in1 && edges[0]) || (mode_run && run_rise));
  assign cap_hit    = run_i && edges[1];
  assign clr        = clr_we_i ? clr_mask_i : '0;

  evt_flag_pair #(.LOCK_ON_ERR(1'b0)) u_flags1 (
    .clk(clk), .rst(rst), .hit_i(reload_hit),
    .clr_ev_i(clr[FLAG_EV1]), .clr_er_i(clr[FLAG_ER1]),
    .accept_o(unused_accept), .ev_o(ev1_f), .er_o(er1_f)
  );

  evt_flag_pair #(.LOCK_ON_ERR(1'b1)) u_flags2 (
    .clk(clk), .rst(rst), .hit_i(cap_hit),
    .clr_ev_i(clr[FLAG_EV2]), .clr_er_i(clr[FLAG_ER2]),
    .accept_o(cap_accept), .ev_o(ev2_f), .er_o(er2_f)
  );

  assign flags_o = {er2_f, ev2_f, er1_f, ev1_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      reload_q  <= '0;
      count_o   <= '0;
      capture_o <= '0;
    end else begin
      run_q <= run_i;
      if (reload_we_i) reload_q <= reload_wdata_i;
      // capture samples the pre-reload count (nonblocking order)
      if (cap_accept) capture_o <= count_o;
      if (reload_hit) count_o <= reload_q;
      else if (tick)  count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/evt_reload_timer_chk.sv
module evt_reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run_i,
  input logic         reload_en_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] capture_o,
  input logic [3:0]   flags_o
);
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!run_i) |-> $stable(count_o));

  assert_no_flag2_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_o[2]) |-> $past(run_i));

  assert_freerun_step_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!reload_en_i) |->
      (count_o == $past(count_o) || count_o == W'($past(count_o) - 1'b1)));

  assert_err1_after_flag1_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_o[1]) |-> $past(flags_o[0]));

  assert_capture_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(capture_o) |-> flags_o[2]);

  assert_capture_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    $past(flags_o[2] || flags_o[3]) |-> $stable(capture_o));
endmodule

bind evt_reload_timer evt_reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run_i(run_i), .reload_en_i(reload_en_i),
  .count_o(count_o), .capture_o(capture_o), .flags_o(flags_o)
);

// File: tb/tb_evt_reload_timer.sv
`timescale 1ns/1ps
module tb_evt_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_i = 1'b0, reload_en_i = 1'b0;
  logic [1:0]  src_sel_i = 2'b01;
  logic        pol1_i = 1'b0, pol2_i = 1'b0;
  logic [15:0] div_i = 16'hFFFF;
  logic        ev1_i = 1'b0, ev2_i = 1'b0;
  logic        reload_we_i = 1'b0;
  logic [15:0] reload_wdata_i = '0;
  logic        clr_we_i = 1'b0;
  logic [3:0]  clr_mask_i = '0;
  logic [15:0] count_o, capture_o;
  logic [3:0]  flags_o;
  logic        idle1 = 1'b0, idle2 = 1'b0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_reload_timer dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_reload(logic [15:0] v);
    @(negedge clk); reload_we_i = 1; reload_wdata_i = v;
    @(negedge clk); reload_we_i = 0;
  endtask

  task automatic clear(logic [3:0] m);
    @(negedge clk); clr_we_i = 1; clr_mask_i = m;
    @(negedge clk); clr_we_i = 0; clr_mask_i = '0;
  endtask

  // toggle selected pins away from idle; return after the action edge
  task automatic fire(bit a, bit b);
    @(negedge clk);
    if (a) ev1_i = ~idle1;
    if (b) ev2_i = ~idle2;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_pins();
    @(negedge clk); ev1_i = idle1; ev2_i = idle2;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 count", count_o, 0);
    chk("R1 capture", capture_o, 0);
    chk("R1 flags", flags_o, 0);
  endtask

  task automatic t_stopped();
    reload_en_i = 1; src_sel_i = 2'b01;
    set_reload(16'h1111);
    fire(1, 1); release_pins();
    chk("R3 count", count_o, 0);
    chk("R3 capture", capture_o, 0);
    chk("R3 flags", flags_o, 0);
  endtask

  task automatic t_prescale();
    reload_en_i = 0; div_i = 16'd3;
    @(negedge clk); run_i = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R2 before first tick", count_o, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R2 wrap", count_o, 16'hFFFF);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R2 second step", count_o, 16'hFFFE);
    run_i = 0;
    repeat (6) @(negedge clk);
    chk("R2 hold when stopped", count_o, 16'hFFFE);
  endtask

  task automatic t_freerun();
    div_i = 16'hFFFF; reload_en_i = 0;
    set_reload(16'h2222);
    @(negedge clk); run_i = 1;
    fire(1, 0); release_pins();
    chk("R4 no reload", count_o, 16'hFFFE);
    chk("R4 no flag1", flags_o, 4'b0000);
    fire(0, 1); release_pins();
    chk("R4 capture still works", capture_o, 16'hFFFE);
    src_sel_i = 2'b10; reload_en_i = 1;
    clear(4'b0100);
    fire(1, 0); release_pins();
    chk("R4 reserved select no reload", count_o, 16'hFFFE);
    chk("R12 clear flag2", flags_o, 4'b0000);
  endtask

  task automatic t_in1_restart();
    src_sel_i = 2'b01; reload_en_i = 1;
    set_reload(16'h1234);
    fire(1, 0);
    chk("R5 reload", count_o, 16'h1234);
    chk("R5 flag1", flags_o, 4'b0001);
    release_pins();
    fire(1, 0);
    chk("R6 err1", flags_o, 4'b0011);
    release_pins();
    clear(4'b0011);
    chk("R12 clear", flags_o, 4'b0000);
  endtask

  task automatic t_capture_lock();
    fire(0, 1); release_pins();
    chk("R7 capture", capture_o, 16'h1234);
    chk("R7 flag2", flags_o, 4'b0100);
    set_reload(16'h5555);
    fire(1, 0); release_pins();
    fire(0, 1); release_pins();
    chk("R8 capture suppressed", capture_o, 16'h1234);
    chk("R8 err2", flags_o, 4'b1101);
    clear(4'b0100);
    fire(0, 1); release_pins();
    chk("R8 locked by err2", capture_o, 16'h1234);
    chk("R8 flags while locked", flags_o, 4'b1001);
    clear(4'b1001);
    fire(0, 1); release_pins();
    chk("R8 unlocked", capture_o, 16'h5555);
    clear(4'b1111);
  endtask

  task automatic t_simultaneous();
    set_reload(16'h0777);
    fire(1, 1);
    chk("R9 capture old count", capture_o, 16'h5555);
    chk("R9 counter reloaded", count_o, 16'h0777);
    chk("R9 both flags", flags_o, 4'b0101);
    release_pins();
    clear(4'b1111);
  endtask

  task automatic t_polarity();
    set_reload(16'h0ABC);
    @(negedge clk); pol1_i = 1;
    @(negedge clk); idle1 = 1; ev1_i = 1;
    repeat (5) @(negedge clk);
    chk("R10 rising ignored", count_o, 16'h0777);
    fire(1, 0);
    chk("R10 falling reloads", count_o, 16'h0ABC);
    release_pins();
    pol1_i = 0; @(negedge clk); idle1 = 0; ev1_i = 0;
    repeat (5) @(negedge clk);
    chk("R10 flags after restore", flags_o, 4'b0001);
  endtask

  task automatic t_clear_vs_set();
    set_reload(16'h0BEE);
    @(negedge clk); ev1_i = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); clr_we_i = 1; clr_mask_i = 4'b0001;
    @(posedge clk);
    @(negedge clk); clr_we_i = 0; clr_mask_i = '0;
    chk("R12 set wins", flags_o, 4'b0011);
    chk("R12 reload happened", count_o, 16'h0BEE);
    release_pins();
    clear(4'b0011);
  endtask

  task automatic t_soft_restart();
    @(negedge clk); run_i = 0; src_sel_i = 2'b00;
    set_reload(16'h4321);
    @(negedge clk); run_i = 1;
    @(negedge clk);
    chk("R11 run-edge reload", count_o, 16'h4321);
    chk("R11 flag1", flags_o, 4'b0001);
    set_reload(16'h9999);
    fire(1, 0); release_pins();
    chk("R11 input1 ignored", count_o, 16'h4321);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_stopped();
    t_prescale();
    t_freerun();
    t_in1_restart();
    t_capture_lock();
    t_simultaneous();
    t_polarity();
    t_clear_vs_set();
    t_soft_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule